// File: doc/BRIEF.md
# Four-Wide Register Rename Map with Per-Instruction Checkpoints

This block sits between decode and scheduling. Each cycle it receives a group of up to four instructions. It replaces each architectural source register number with the physical register that currently holds that value. It gives each architectural destination a fresh physical register taken from a pool of free ones. Later lanes in the same group see the new mappings made by earlier lanes, so a read-after-write between neighbours in one group resolves to the producer's new tag. Two writers of the same architectural register always receive different physical registers, which removes write-after-write and write-after-read hazards.

Every accepted instruction occupies one in-flight slot, numbered in program order. The slot keeps three things: a copy of the whole map as it stood just before that instruction, the physical register that the instruction displaced, and the register it was given. Retirement releases the oldest slots in order and returns each displaced register to the pool. A flush names a slot. The map is rewound to that slot's copy, and that slot and every younger one are dropped, with their newly given registers going back to the pool. During a flush cycle the incoming group and the retire count are both ignored. Retirement and renaming in the same cycle see the state from before that cycle.

Top module: `rename_map`

## Requirements
- R1: After reset, architectural register i maps to physical register i. The pool holds every physical register numbered NARCH and above. No slot is in flight, and `ren_ok` is low while no lane is valid.
- R2: Each valid lane reports two source tags. A source that no earlier lane of the group writes reads the map table.
- R3: Lanes that need a destination take the lowest-numbered free physical registers, in lane order, one each. No two lanes of one group receive the same register.
- R4: A lane whose source is written by an earlier valid lane of the same group receives the new tag of the youngest such earlier lane.
- R5: `ren_old` reports the physical register that held the lane's destination just before that lane. This includes a register given to an earlier lane of the same group.
- R6: Architectural register 31 always reads as physical tag 31 and is never given a new register. A lane that writes register 31, or has `grp_dst_en` low, reports 31 on both `ren_new` and `ren_old`. Tag 31 never enters the pool.
- R7: If the pool holds fewer registers than the group needs, `ren_ok` is low and no lane is renamed. The map and the pool stay unchanged.
- R8: Valid lanes take consecutive in-flight slots modulo DEPTH, starting at the next free one. If fewer slots remain than valid lanes, `ren_ok` is low and nothing is renamed.
- R9: `ret_cnt` retires that many of the oldest slots. The displaced register of each slot that allocated returns to the pool.
- R10: With `flush_en` high, `ren_ok` is low. On the next edge the map becomes the copy saved for `flush_slot`, that slot and all younger ones leave the in-flight set, and their new registers return to the pool.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| grp_valid | input | LANES | Lane holds an instruction |
| grp_dst_en | input | LANES | Lane writes a destination |
| grp_dst | input | LANES*AW | Architectural destination per lane |
| grp_src_a | input | LANES*AW | First architectural source per lane |
| grp_src_b | input | LANES*AW | Second architectural source per lane |
| ren_ok | output | 1 | Whole group accepted this cycle |
| ren_src_a | output | LANES*PW | Physical tag of first source |
| ren_src_b | output | LANES*PW | Physical tag of second source |
| ren_new | output | LANES*PW | Newly given destination tag |
| ren_old | output | LANES*PW | Displaced destination tag |
| ren_slot | output | LANES*SW | In-flight slot given to the lane |
| ret_cnt | input | LW | Number of oldest slots retiring |
| flush_en | input | 1 | Rewind to a slot and drop younger work |
| flush_slot | input | SW | Slot whose saved map is restored |

## Verification
The pool-exhaustion stall is the hardest case to reach from the ports. With the default sizes the in-flight slots run out long before the 48 spare registers do, so the bench builds the block with only eight spare registers and drains the pool through renamed groups. Once the pool is empty, retiring a slot whose destination was register 31 must still leave a two-destination group stalled, which shows that tag 31 never reaches the pool. The bench then flushes into the middle of a group and checks both the restored sources and the exact tags handed out again. A final run of destination-less groups fills the slot ring across its wrap point.

// File: rtl/rename_map.sv
module rename_map #(
  parameter int NARCH = 32,
  parameter int NPHYS = 80,
  parameter int LANES = 4,
  parameter int DEPTH = 16,
  parameter int ZREG  = 31,
  localparam int AW = $clog2(NARCH),
  localparam int PW = $clog2(NPHYS),
  localparam int SW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int LW = $clog2(LANES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LANES-1:0]    grp_valid,
  input  logic [LANES-1:0]    grp_dst_en,
  input  logic [LANES*AW-1:0] grp_dst,
  input  logic [LANES*AW-1:0] grp_src_a,
  input  logic [LANES*AW-1:0] grp_src_b,
  output logic               ren_ok,
  output logic [LANES*PW-1:0] ren_src_a,
  output logic [LANES*PW-1:0] ren_src_b,
  output logic [LANES*PW-1:0] ren_new,
  output logic [LANES*PW-1:0] ren_old,
  output logic [LANES*SW-1:0] ren_slot,
  input  logic [LW-1:0]       ret_cnt,
  input  logic               flush_en,
  input  logic [SW-1:0]       flush_slot
);
  localparam logic [AW-1:0] ZDST = AW'(ZREG);
  localparam logic [PW-1:0] ZTAG = PW'(ZREG);

  function automatic logic [SW-1:0] wrap(input int v);
    return SW'(v % DEPTH);
  endfunction

  logic [PW-1:0]    map_q   [NARCH];
  logic [NPHYS-1:0] free_q;
  logic [PW-1:0]    snap_q  [DEPTH][NARCH];
  logic [PW-1:0]    prev_q  [DEPTH];
  logic [PW-1:0]    fresh_q [DEPTH];
  logic [DEPTH-1:0] alloc_q;
  logic [SW-1:0]    head_q, tail_q;
  logic [CW-1:0]    cnt_q;

  logic [PW-1:0]    run_map   [NARCH];
  logic [PW-1:0]    lane_snap [LANES][NARCH];
  logic [PW-1:0]    sa_t [LANES], sb_t [LANES], new_t [LANES], old_t [LANES];
  logic [SW-1:0]    slot_t [LANES];
  logic [LANES-1:0] takes;
  logic [NPHYS-1:0] avail, grab;
  logic [PW-1:0]    pick;
  logic             found, all_found;
  int               nval;

  always_comb begin
    run_map   = map_q;
    avail     = free_q;
    grab      = '0;
    all_found = 1'b1;
    nval      = 0;
    takes     = '0;
    pick      = '0;
    found     = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      lane_snap[l] = run_map;
      sa_t[l] = (grp_src_a[l*AW +: AW] == ZDST) ? ZTAG : run_map[grp_src_a[l*AW +: AW]];
      sb_t[l] = (grp_src_b[l*AW +: AW] == ZDST) ? ZTAG : run_map[grp_src_b[l*AW +: AW]];
      slot_t[l] = wrap(int'(tail_q) + nval);
      new_t[l] = ZTAG;
      old_t[l] = ZTAG;
      if (grp_valid[l]) nval++;
      takes[l] = grp_valid[l] && grp_dst_en[l] && (grp_dst[l*AW +: AW] != ZDST);
      if (takes[l]) begin
        found = 1'b0;
        pick  = '0;
        for (int k = NPHYS - 1; k >= 0; k--) begin
          if (avail[k]) begin
            found = 1'b1;
            pick  = PW'(k);
          end
        end
        if (!found) all_found = 1'b0;
        if (found) begin
          avail[pick] = 1'b0;
          grab[pick]  = 1'b1;
        end
        new_t[l] = pick;
        old_t[l] = run_map[grp_dst[l*AW +: AW]];
        run_map[grp_dst[l*AW +: AW]] = pick;
      end
    end
  end

  assign ren_ok = (|grp_valid) && !flush_en && all_found && (nval <= DEPTH - int'(cnt_q));

  for (genvar l = 0; l < LANES; l++) begin : g_out
    assign ren_src_a[l*PW +: PW] = sa_t[l];
    assign ren_src_b[l*PW +: PW] = sb_t[l];
    assign ren_new[l*PW +: PW]   = new_t[l];
    assign ren_old[l*PW +: PW]   = old_t[l];
    assign ren_slot[l*SW +: SW]  = slot_t[l];
  end

  logic [NPHYS-1:0] ret_free, fl_free;
  int n_ret, keep, off;

  always_comb begin
    n_ret    = (int'(ret_cnt) < int'(cnt_q)) ? int'(ret_cnt) : int'(cnt_q);
    ret_free = '0;
    for (int i = 0; i < LANES; i++) begin
      if (i < n_ret && alloc_q[wrap(int'(head_q) + i)])
        ret_free[prev_q[wrap(int'(head_q) + i)]] = 1'b1;
    end
    keep    = (int'(flush_slot) - int'(head_q) + DEPTH) % DEPTH;
    fl_free = '0;
    off     = 0;
    for (int k = 0; k < DEPTH; k++) begin
      off = (k - int'(head_q) + DEPTH) % DEPTH;
      if (off >= keep && off < int'(cnt_q) && alloc_q[k])
        fl_free[fresh_q[k]] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NARCH; i++) map_q[i] <= PW'(i);
      for (int k = 0; k < NPHYS; k++) free_q[k] <= (k >= NARCH);
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (flush_en) begin
      map_q  <= snap_q[flush_slot];
      free_q <= free_q | fl_free;
      tail_q <= wrap(int'(head_q) + keep);
      cnt_q  <= CW'(keep);
    end else begin
      free_q <= (free_q & ~(ren_ok ? grab : '0)) | ret_free;
      if (ren_ok) map_q <= run_map;
      head_q <= wrap(int'(head_q) + n_ret);
      tail_q <= wrap(int'(tail_q) + (ren_ok ? nval : 0));
      cnt_q  <= CW'(int'(cnt_q) - n_ret + (ren_ok ? nval : 0));
    end
  end

  always_ff @(posedge clk) begin
    if (ren_ok) begin
      for (int l = 0; l < LANES; l++) begin
        if (grp_valid[l]) begin
          snap_q[slot_t[l]]  <= lane_snap[l];
          prev_q[slot_t[l]]  <= old_t[l];
          fresh_q[slot_t[l]] <= new_t[l];
          alloc_q[slot_t[l]] <= takes[l];
        end
      end
    end
  end
endmodule

// File: rtl/rename_map_chk.sv
module rename_map_chk #(
  parameter int NARCH = 32,
  parameter int NPHYS = 80,
  parameter int LANES = 4,
  parameter int DEPTH = 16,
  parameter int ZREG  = 31,
  localparam int AW = $clog2(NARCH),
  localparam int PW = $clog2(NPHYS),
  localparam int SW = $clog2(DEPTH)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [LANES-1:0]    grp_valid,
  input logic [LANES-1:0]    grp_dst_en,
  input logic [LANES*AW-1:0] grp_dst,
  input logic [LANES*AW-1:0] grp_src_a,
  input logic               ren_ok,
  input logic [LANES*PW-1:0] ren_src_a,
  input logic [LANES*PW-1:0] ren_new,
  input logic [LANES*SW-1:0] ren_slot,
  input logic               flush_en
);
  AST_OK_NEEDS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    ren_ok |-> (|grp_valid) && !flush_en); // R7
  AST_FLUSH_HOLDS_RENAME: assert property (@(posedge clk) disable iff (!rst_n)
    flush_en |-> !ren_ok); // R10
  AST_SLOT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_ok && grp_valid[0] && grp_valid[1]) |->
      (int'(ren_slot[SW +: SW]) == (int'(ren_slot[0 +: SW]) + 1) % DEPTH)); // R8

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    AST_ZERO_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      (ren_ok && grp_valid[l] && int'(grp_src_a[l*AW +: AW]) == ZREG) |->
        int'(ren_src_a[l*PW +: PW]) == ZREG); // R6
    AST_NO_ZERO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
      (ren_ok && grp_valid[l] && grp_dst_en[l] && int'(grp_dst[l*AW +: AW]) != ZREG) |->
        (int'(ren_new[l*PW +: PW]) != ZREG && int'(ren_new[l*PW +: PW]) < NPHYS)); // R6
    for (genvar j = l + 1; j < LANES; j++) begin : g_pair
      AST_DISTINCT_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_ok && grp_valid[l] && grp_dst_en[l] && int'(grp_dst[l*AW +: AW]) != ZREG &&
         grp_valid[j] && grp_dst_en[j] && int'(grp_dst[j*AW +: AW]) != ZREG) |->
          ren_new[l*PW +: PW] != ren_new[j*PW +: PW]); // R3
    end
  end

  AST_GROUP_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_ok && grp_valid[0] && grp_dst_en[0] && int'(grp_dst[0 +: AW]) != ZREG &&
     grp_valid[1] && grp_src_a[AW +: AW] == grp_dst[0 +: AW]) |->
      ren_src_a[PW +: PW] == ren_new[0 +: PW]); // R4
endmodule

bind rename_map rename_map_chk #(
  .NARCH(NARCH), .NPHYS(NPHYS), .LANES(LANES), .DEPTH(DEPTH), .ZREG(ZREG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .grp_valid(grp_valid), .grp_dst_en(grp_dst_en),
  .grp_dst(grp_dst), .grp_src_a(grp_src_a), .ren_ok(ren_ok),
  .ren_src_a(ren_src_a), .ren_new(ren_new), .ren_slot(ren_slot), .flush_en(flush_en)
);

// File: tb/tb_rename_map.sv
`timescale 1ns/1ps
module tb_rename_map;
  localparam int LANES = 4, AW = 5, PW = 6, SW = 4, LW = 3, NPHYS = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [LANES-1:0] grp_valid, grp_dst_en;
  logic [LANES*AW-1:0] grp_dst, grp_src_a, grp_src_b;
  logic ren_ok;
  logic [LANES*PW-1:0] ren_src_a, ren_src_b, ren_new, ren_old;
  logic [LANES*SW-1:0] ren_slot;
  logic [LW-1:0] ret_cnt;
  logic flush_en;
  logic [SW-1:0] flush_slot;

  rename_map #(.NPHYS(NPHYS)) dut (
    .clk(clk), .rst_n(rst_n), .grp_valid(grp_valid), .grp_dst_en(grp_dst_en),
    .grp_dst(grp_dst), .grp_src_a(grp_src_a), .grp_src_b(grp_src_b),
    .ren_ok(ren_ok), .ren_src_a(ren_src_a), .ren_src_b(ren_src_b),
    .ren_new(ren_new), .ren_old(ren_old), .ren_slot(ren_slot),
    .ret_cnt(ret_cnt), .flush_en(flush_en), .flush_slot(flush_slot)
  );

  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [3:0]  v;
    logic [3:0]  de;
    logic [19:0] dst;
    logic [19:0] sa;
    logic [19:0] sb;
    logic        ok;
    logic [23:0] esa;
    logic [23:0] esb;
    logic [23:0] enew;
    logic [23:0] eold;
  } vec_t;

  // lane 3 is the leftmost field of every concatenation
  localparam vec_t VECS [3] = '{
    '{4'b1111, 4'b1111,
      {5'd4, 5'd1, 5'd2, 5'd1}, {5'd1, 5'd3, 5'd1, 5'd2}, {5'd2, 5'd1, 5'd3, 5'd3}, 1'b1,
      {6'd34, 6'd3, 6'd32, 6'd2}, {6'd33, 6'd32, 6'd3, 6'd3},
      {6'd35, 6'd34, 6'd33, 6'd32}, {6'd4, 6'd32, 6'd2, 6'd1}},
    '{4'b0101, 4'b0111,
      {5'd0, 5'd5, 5'd5, 5'd31}, {5'd0, 5'd31, 5'd7, 5'd31}, {5'd0, 5'd4, 5'd7, 5'd1}, 1'b1,
      {6'd0, 6'd31, 6'd0, 6'd31}, {6'd0, 6'd35, 6'd0, 6'd34},
      {6'd0, 6'd36, 6'd0, 6'd31}, {6'd0, 6'd5, 6'd0, 6'd31}},
    '{4'b1111, 4'b1010,
      {5'd6, 5'd6, 5'd6, 5'd6}, {5'd6, 5'd6, 5'd1, 5'd5}, {5'd0, 5'd4, 5'd2, 5'd6}, 1'b1,
      {6'd37, 6'd37, 6'd34, 6'd36}, {6'd0, 6'd35, 6'd33, 6'd6},
      {6'd38, 6'd31, 6'd37, 6'd31}, {6'd37, 6'd31, 6'd6, 6'd31}}
  };

  int total = 0, bad = 0;
  bit done = 1'b0;

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    grp_valid = '0; grp_dst_en = '0; grp_dst = '0; grp_src_a = '0; grp_src_b = '0;
    ret_cnt = '0; flush_en = 1'b0; flush_slot = '0;
  endtask

  task automatic lane(int l, int de, int d, int a, int b);
    grp_valid[l] = 1'b1;
    grp_dst_en[l] = de[0];
    grp_dst[l*AW +: AW] = AW'(d);
    grp_src_a[l*AW +: AW] = AW'(a);
    grp_src_b[l*AW +: AW] = AW'(b);
  endtask

  function automatic int t_sa(int l); return int'(ren_src_a[l*PW +: PW]); endfunction
  function automatic int t_sb(int l); return int'(ren_src_b[l*PW +: PW]); endfunction
  function automatic int t_new(int l); return int'(ren_new[l*PW +: PW]); endfunction
  function automatic int t_old(int l); return int'(ren_old[l*PW +: PW]); endfunction
  function automatic int t_slot(int l); return int'(ren_slot[l*SW +: SW]); endfunction

  initial begin
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R1", "ren_ok idle after reset", int'(ren_ok), 0);

    // table: R1 identity map, R2 lookup, R3 allocation, R4 in-group forward, R5 old tag, R6 zero reg
    foreach (VECS[i]) begin
      @(negedge clk);
      idle();
      grp_valid = VECS[i].v; grp_dst_en = VECS[i].de; grp_dst = VECS[i].dst;
      grp_src_a = VECS[i].sa; grp_src_b = VECS[i].sb;
      #1;
      chk("R7", "ren_ok table", int'(ren_ok), int'(VECS[i].ok));
      for (int l = 0; l < LANES; l++) begin
        if (VECS[i].v[l]) begin
          chk("R2 R4 R1", "src_a", t_sa(l), int'(VECS[i].esa[l*PW +: PW]));
          chk("R2 R4 R6", "src_b", t_sb(l), int'(VECS[i].esb[l*PW +: PW]));
          chk("R3 R6", "new", t_new(l), int'(VECS[i].enew[l*PW +: PW]));
          chk("R5 R6", "old", t_old(l), int'(VECS[i].eold[l*PW +: PW]));
        end
      end
    end

    // R7: one free register left, group needs two
    @(negedge clk); idle();
    lane(0, 1, 7, 0, 0); lane(1, 1, 8, 0, 0);
    #1 chk("R7", "stall when pool short", int'(ren_ok), 0);
    @(negedge clk); idle();
    lane(0, 1, 9, 7, 8);
    #1;
    chk("R7", "single accepted", int'(ren_ok), 1);
    chk("R7", "r7 unmapped after stall", t_sa(0), 7);
    chk("R7", "r8 unmapped after stall", t_sb(0), 8);
    chk("R7", "last free reg unused by stall", t_new(0), 39);
    chk("R8", "slot after ten", t_slot(0), 10);

    // R9: retire three oldest, freeing 1, 2, 32
    @(negedge clk); idle(); ret_cnt = 3'd3;
    @(negedge clk); idle();
    lane(0, 1, 10, 0, 0); lane(1, 1, 11, 0, 0); lane(2, 1, 12, 0, 0);
    #1;
    chk("R9", "accept after retire", int'(ren_ok), 1);
    chk("R9", "freed lane0", t_new(0), 1);
    chk("R9", "freed lane1", t_new(1), 2);
    chk("R9", "freed lane2", t_new(2), 32);

    // R9 R6: retire a real writer and a zero-reg writer, only tag 4 returns
    @(negedge clk); idle(); ret_cnt = 3'd2;
    @(negedge clk); idle();
    lane(0, 1, 20, 0, 0); lane(1, 1, 21, 0, 0);
    #1 chk("R6 R9", "zero tag never freed", int'(ren_ok), 0);
    @(negedge clk); idle();
    lane(0, 1, 22, 0, 0);
    #1;
    chk("R9", "tag 4 freed", t_new(0), 4);
    chk("R8", "slot 14", t_slot(0), 14);

    // R10: flush to slot 12
    @(negedge clk); idle();
    flush_en = 1'b1; flush_slot = 4'd12;
    lane(0, 1, 23, 0, 0);
    #1 chk("R10", "no rename during flush", int'(ren_ok), 0);
    @(negedge clk); idle();
    lane(0, 1, 13, 10, 11); lane(1, 1, 14, 12, 22); lane(2, 1, 15, 9, 0);
    #1;
    chk("R10", "accept after flush", int'(ren_ok), 1);
    chk("R10", "r10 kept", t_sa(0), 1);
    chk("R10", "r11 restored", t_sb(0), 11);
    chk("R10", "r12 restored", t_sa(1), 12);
    chk("R10", "r22 restored", t_sb(1), 22);
    chk("R10", "r9 kept", t_sa(2), 39);
    chk("R10", "reissue lane0", t_new(0), 2);
    chk("R10", "reissue lane1", t_new(1), 4);
    chk("R10", "reissue lane2", t_new(2), 32);
    chk("R10", "slot reuse", t_slot(0), 12);

    // R8: fill slot ring across wrap
    @(negedge clk); idle();
    for (int l = 0; l < 4; l++) lane(l, 0, 0, 0, 0);
    #1;
    chk("R8", "four fit", int'(ren_ok), 1);
    chk("R8", "wrap slot lane0", t_slot(0), 15);
    chk("R8", "wrap slot lane1", t_slot(1), 0);
    chk("R8", "wrap slot lane3", t_slot(3), 2);
    chk("R6", "no-dest new tag", t_new(2), 31);
    @(negedge clk); idle();
    for (int l = 0; l < 4; l++) lane(l, 0, 0, 0, 0);
    #1 chk("R8", "too few slots", int'(ren_ok), 0);
    @(negedge clk); idle();
    lane(0, 0, 0, 0, 0); lane(1, 0, 0, 0, 0);
    #1;
    chk("R8", "last two fit", int'(ren_ok), 1);
    chk("R8", "slot 4", t_slot(1), 4);
    @(negedge clk); idle();
    lane(0, 0, 0, 0, 0);
    #1 chk("R8", "ring full", int'(ren_ok), 0);

    @(negedge clk); idle();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule